// File: doc/BRIEF.md
# Parallel I/O Port with Edge Capture

This block is a general-purpose parallel I/O port of `WIDTH` bits, run by a bus host through a small word-addressed register file. The host writes a value for the output pins and picks the direction of each pin. It reads the input pins after they pass through a synchronizer. A separate bus-write command sets or clears chosen output bits, so the host never needs a read-modify-write.

Each input bit has a sticky capture flag that records an edge of the polarity chosen at build time. A per-bit enable register selects which flags can drive a single level interrupt. The rule for clearing flags is also fixed at build time: either any write to the flag register clears every flag, or only the bits written as 1 are cleared.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the output value, direction, interrupt enable and capture flags are all zero, so every pin is an input (`pin_oe` = 0) and `irq` is 0.
- R2: A read takes effect one clock after `rd`. At that point `rdata` holds the register selected by `addr`, zero-extended to 32 bits. A read at offset 0 returns the input pins after a two-flop synchronizer: a pin change is visible to a read strobed two or more cycles later, and is not visible to a read strobed in the cycle right after the change.
- R3: A write at offset 0 loads `wdata[WIDTH-1:0]` into the output value, and `pin_out` shows it one clock later.
- R4: Offset 1 is the direction register. A 1 bit drives `pin_oe` high (output) and a 0 bit makes the pin an input. It reads back as written.
- R5: A write at offset 4 sets the `pin_out` bits where `wdata` is 1. A write at offset 5 clears the `pin_out` bits where `wdata` is 1. All other bits keep their value. Reads at offsets 4 and 5 return zero.
- R6: Offset 3 holds one sticky capture flag per input bit. The flag is set on an edge of the build-selected polarity (`EDGE_MODE` 0 rising, 1 falling, 2 both), seen on the synchronized input. An edge of the other polarity leaves the flag unchanged.
- R7: With `BIT_CLEAR`=1, a write at offset 3 clears only the flags whose `wdata` bit is 1. With `BIT_CLEAR`=0, any write at offset 3 clears all flags, whatever the data.
- R8: If an edge and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R9: Offset 2 is the interrupt enable register and reads back as written. `irq` is a register holding the OR over all bits of (flag AND enable), and it follows a change of either input one clock later.
- R10: Offsets 6 and 7 read as zero, and writes to them change no output or register.
- R11: With `EDGE_MODE`=2, both rising and falling edges set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Word offset of the register |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one clock after `rd` |
| pin_in | input | WIDTH | Input pins (asynchronous) |
| pin_out | output | WIDTH | Output value |
| pin_oe | output | WIDTH | Per-bit output enable |
| irq | output | 1 | Level interrupt |

## Verification
Each result has its own latency, and the bench waits for it:

| Result | Due |
|---|---|
| `pin_out`, `pin_oe`, register contents | Clock after the write |
| `rdata` | Clock after the read strobe |
| Synchronized pin value | Second clock after a pin change |
| Capture flag | Third clock after a pin change |
| `irq` | One clock after the flag or enable register changes |

The bench drives and samples on the falling edge. For the `irq` latency, it checks the output both at the falling edge before it is due and at the falling edge after. For the edge-versus-clear case, it places the clearing write on the exact edge that sets the flag. It also reads the pins once too early, to confirm that the synchronizer delay is present.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int unsigned ADDR_W = 3;
  localparam int unsigned BUS_W  = 32;

  localparam logic [ADDR_W-1:0] OFS_PINS = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_CAP  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_SET  = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 3'd5;

  localparam int unsigned EDGE_RISE = 0;
  localparam int unsigned EDGE_FALL = 1;
  localparam int unsigned EDGE_BOTH = 2;

  // One-bit edge decision for a synchronized sample and its previous value.
  function automatic logic edge_fire(logic cur, logic prv, int unsigned mode);
    case (mode)
      EDGE_RISE: edge_fire = cur & ~prv;
      EDGE_FALL: edge_fire = ~cur & prv;
      default:   edge_fire = cur ^ prv;
    endcase
  endfunction

  // New output word after set and clear masks are applied.
  function automatic logic [BUS_W-1:0] set_clr(logic [BUS_W-1:0] old,
                                               logic [BUS_W-1:0] setm,
                                               logic [BUS_W-1:0] clrm);
    set_clr = (old | setm) & ~clrm;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned EDGE_MODE = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] sync_val,
  output logic [WIDTH-1:0] edge_hit
);
  import gpio_pkg::*;

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      prev_q   <= '0;
    end else begin
      stage1_q <= pin_in;
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  assign sync_val = stage2_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_edge
    assign edge_hit[b] = edge_fire(stage2_q[b], prev_q[b], EDGE_MODE);
  end

endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags #(
  parameter int unsigned WIDTH     = 8,
  parameter bit          BIT_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] edge_hit,
  input  logic             clr_wr,
  input  logic [WIDTH-1:0] clr_data,
  output logic [WIDTH-1:0] flags
);
  logic [WIDTH-1:0] keep_mask;
  logic [WIDTH-1:0] flags_d;

  if (BIT_CLEAR) begin : g_bitwise
    assign keep_mask = clr_wr ? ~clr_data : '1;
  end else begin : g_wholesale
    logic unused_clr_data;
    assign unused_clr_data = ^clr_data;
    assign keep_mask = clr_wr ? '0 : '1;
  end

  // An edge in the clearing cycle wins over the clear.
  assign flags_d = (flags & keep_mask) | edge_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end

endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_val,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic             wr_dir,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] oe_q
);
  import gpio_pkg::*;

  logic [BUS_W-1:0] setm;
  logic [BUS_W-1:0] clrm;
  logic [BUS_W-1:0] merged;
  logic [WIDTH-1:0] out_d;
  logic             unused_merged;

  assign setm   = wr_set ? BUS_W'(wdata) : '0;
  assign clrm   = wr_clr ? BUS_W'(wdata) : '0;
  assign merged = set_clr(BUS_W'(out_q), setm, clrm);
  assign unused_merged = ^merged;

  always_comb begin
    if (wr_val) out_d = wdata;
    else        out_d = merged[WIDTH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= '0;
    end else begin
      out_q <= out_d;
      if (wr_dir) oe_q <= wdata;
    end
  end

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned EDGE_MODE = 0,
  parameter bit          BIT_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       addr,
  input  logic             rd,
  input  logic             wr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe,
  output logic             irq
);
  import gpio_pkg::*;

  logic [WIDTH-1:0] wd;
  logic             unused_wdata;
  logic             wr_val, wr_dir, wr_ien, wr_cap, wr_set, wr_clr;
  logic [WIDTH-1:0] sync_val;
  logic [WIDTH-1:0] edge_hit;
  logic [WIDTH-1:0] cap_flags;
  logic [WIDTH-1:0] irq_mask;
  logic             irq_d;
  logic [BUS_W-1:0] rd_val;

  assign wd           = wdata[WIDTH-1:0];
  assign unused_wdata = ^wdata;

  assign wr_val = wr && (addr == OFS_PINS);
  assign wr_dir = wr && (addr == OFS_DIR);
  assign wr_ien = wr && (addr == OFS_IEN);
  assign wr_cap = wr && (addr == OFS_CAP);
  assign wr_set = wr && (addr == OFS_SET);
  assign wr_clr = wr && (addr == OFS_CLR);

  gpio_in_sync #(.WIDTH(WIDTH), .EDGE_MODE(EDGE_MODE)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .sync_val (sync_val),
    .edge_hit (edge_hit)
  );

  gpio_edge_flags #(.WIDTH(WIDTH), .BIT_CLEAR(BIT_CLEAR)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_hit (edge_hit),
    .clr_wr   (wr_cap),
    .clr_data (wd),
    .flags    (cap_flags)
  );

  gpio_out_reg #(.WIDTH(WIDTH)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_val (wr_val),
    .wr_set (wr_set),
    .wr_clr (wr_clr),
    .wr_dir (wr_dir),
    .wdata  (wd),
    .out_q  (pin_out),
    .oe_q   (pin_oe)
  );

  assign irq_d = |(cap_flags & irq_mask);

  always_comb begin
    case (addr)
      OFS_PINS: rd_val = BUS_W'(sync_val);
      OFS_DIR:  rd_val = BUS_W'(pin_oe);
      OFS_IEN:  rd_val = BUS_W'(irq_mask);
      OFS_CAP:  rd_val = BUS_W'(cap_flags);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_mask <= '0;
      irq      <= 1'b0;
      rdata    <= '0;
    end else begin
      if (wr_ien) irq_mask <= wd;
      irq <= irq_d;
      if (rd) rdata <= rd_val;
    end
  end

endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr,
  input logic [2:0]       addr,
  input logic [WIDTH-1:0] wd,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe,
  input logic             irq,
  input logic [WIDTH-1:0] edge_hit,
  input logic [WIDTH-1:0] cap_flags,
  input logic [WIDTH-1:0] irq_mask
);

  AST_VALUE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 3'd0) |=> pin_out == $past(wd)); // R3

  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 3'd1) |=> pin_oe == $past(wd)); // R4

  AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 3'd4) |=> pin_out == ($past(pin_out) | $past(wd))); // R5

  AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 3'd5) |=> pin_out == ($past(pin_out) & ~$past(wd))); // R5

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> (cap_flags & $past(edge_hit)) == $past(edge_hit)); // R8

  AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|(cap_flags & irq_mask))); // R9

  AST_HOLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr[2:1] == 2'b11) |=> $stable(pin_out) && $stable(pin_oe)
      && $stable(irq_mask)); // R10

endmodule

bind gpio_edge_port gpio_edge_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr        (wr),
  .addr      (addr),
  .wd        (wdata[WIDTH-1:0]),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .edge_hit  (edge_hit),
  .cap_flags (cap_flags),
  .irq_mask  (irq_mask)
);

// File: tb/gpio_edge_port_test.sv
`timescale 1ns/1ps
module gpio_edge_port_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata2;
  logic [7:0]  pin_in = '0, pin_in2 = '0;
  logic [7:0]  pin_out, pin_oe, pin_out2, pin_oe2;
  logic        irq, irq2;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  gpio_edge_port #(.WIDTH(8), .EDGE_MODE(0), .BIT_CLEAR(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  gpio_edge_port #(.WIDTH(8), .EDGE_MODE(2), .BIT_CLEAR(1'b0)) uut_all (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rdata2), .pin_in(pin_in2), .pin_out(pin_out2), .pin_oe(pin_oe2), .irq(irq2));

  typedef struct packed {
    logic [2:0]  a;
    logic [31:0] d;
    logic [7:0]  exp_out;
    logic [7:0]  exp_oe;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 32'h0000_00A5, 8'hA5, 8'h00},
    '{3'd1, 32'h0000_000F, 8'hA5, 8'h0F},
    '{3'd4, 32'h0000_000A, 8'hAF, 8'h0F},
    '{3'd5, 32'h0000_0081, 8'h2E, 8'h0F},
    '{3'd4, 32'h0000_0100, 8'h2E, 8'h0F},
    '{3'd5, 32'h0000_0000, 8'h2E, 8'h0F},
    '{3'd1, 32'h0000_00F0, 8'h2E, 8'hF0},
    '{3'd0, 32'hFFFF_FF3C, 8'h3C, 8'hF0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] r, output logic [31:0] r2);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    r = rdata; r2 = rdata2;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] r, r2;
    settle(3);
    rst_n = 1'b1;
    settle(1);

    // R1: reset state
    check("R1 pin_out", 32'(pin_out), 32'h0);
    check("R1 pin_oe", 32'(pin_oe), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    bus_rd(3'd1, r, r2); check("R1 dir", r, 32'h0);
    bus_rd(3'd2, r, r2); check("R1 ien", r, 32'h0);
    bus_rd(3'd3, r, r2); check("R1 flags", r, 32'h0);

    // R3 R4 R5: vector table of writes and output state
    for (int i = 0; i < NV; i++) begin
      bus_wr(VEC[i].a, VEC[i].d);
      check($sformatf("R3/R4/R5 vec%0d pin_out", i), 32'(pin_out), 32'(VEC[i].exp_out));
      check($sformatf("R4 vec%0d pin_oe", i), 32'(pin_oe), 32'(VEC[i].exp_oe));
    end
    bus_rd(3'd1, r, r2); check("R4 dir readback", r, 32'h0000_00F0);
    bus_rd(3'd4, r, r2); check("R5 set offset reads zero", r, 32'h0);
    bus_rd(3'd5, r, r2); check("R5 clr offset reads zero", r, 32'h0);

    // R10: holes
    bus_wr(3'd6, 32'hFFFF_FFFF);
    bus_wr(3'd7, 32'hFFFF_FFFF);
    check("R10 pin_out after hole write", 32'(pin_out), 32'h3C);
    check("R10 pin_oe after hole write", 32'(pin_oe), 32'hF0);
    bus_rd(3'd2, r, r2); check("R10 ien after hole write", r, 32'h0);
    bus_rd(3'd6, r, r2); check("R10 read offset 6", r, 32'h0);
    bus_rd(3'd7, r, r2); check("R10 read offset 7", r, 32'h0);

    // R2: synchronizer latency
    @(negedge clk);
    pin_in = 8'h5A;
    bus_rd(3'd0, r, r2); check("R2 early read old value", r, 32'h0);
    bus_rd(3'd0, r, r2); check("R2 synced value", r, 32'h0000_005A);

    // R6: rising edges captured
    settle(2);
    bus_rd(3'd3, r, r2); check("R6 rising flags", r, 32'h0000_005A);
    check("R9 irq masked off", 32'(irq), 32'h0);

    // R9: enable -> irq one clock later
    bus_wr(3'd2, 32'h0000_0002);
    check("R9 irq not yet", 32'(irq), 32'h0);
    settle(1);
    check("R9 irq raised", 32'(irq), 32'h1);
    bus_rd(3'd2, r, r2); check("R9 ien readback", r, 32'h2);

    // R7: write-one clears only that bit
    bus_wr(3'd3, 32'h0000_0002);
    bus_rd(3'd3, r, r2); check("R7 bit clear", r, 32'h0000_0058);
    check("R9 irq dropped", 32'(irq), 32'h0);

    // R6: falling edges ignored in rising mode
    @(negedge clk);
    pin_in = 8'h00;
    settle(5);
    bus_rd(3'd3, r, r2); check("R6 falling ignored", r, 32'h0000_0058);
    bus_wr(3'd3, 32'h0000_0058);
    bus_rd(3'd3, r, r2); check("R7 bit clear rest", r, 32'h0);

    // R8: edge and clear in the same cycle
    @(negedge clk);
    pin_in = 8'h01;
    @(posedge clk);
    @(posedge clk);
    bus_wr(3'd3, 32'h0000_0001);
    bus_rd(3'd3, r, r2); check("R8 edge wins over clear", r, 32'h1);
    check("R9 irq unmasked bit", 32'(irq), 32'h0);
    bus_wr(3'd3, 32'h0000_0001);
    bus_rd(3'd3, r, r2); check("R8 later clear works", r, 32'h0);

    // R11 / R7 on the both-edge, clear-all instance
    @(negedge clk);
    pin_in2 = 8'h0F;
    settle(5);
    bus_rd(3'd3, r, r2); check("R11 rising in both mode", r2, 32'h0F);
    bus_wr(3'd3, 32'h0);
    bus_rd(3'd3, r, r2); check("R7 any write clears all", r2, 32'h0);
    @(negedge clk);
    pin_in2 = 8'h03;
    settle(5);
    bus_rd(3'd3, r, r2); check("R11 falling in both mode", r2, 32'h0C);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule